// File: doc/BRIEF.md
# Attention-Mode Command Decoder with Talk/Listen Addressing

This block sits behind the byte-level receive handshake of an instrument bus port. Each accepted byte arrives with a one-cycle strobe. When the attention line is asserted, the byte is an interface command. The block decodes it against the device's 5-bit configured address and keeps the device's addressed roles: talker, listener, remote and lockout. It also emits one-cycle pulses that ask the rest of the device to clear or to trigger. When the attention line is released, the byte is device data and goes out unchanged on a separate strobe.

The decode ignores the top bit of each command byte. A device is addressed when it sees its own listen or talk address. It loses that role on the unlisten or untalk byte, on the opposite own address, or, for the talker role only, on another device's talk address. Commands aimed at a selected device act only while the device is an addressed listener. The interface-clear level overrides all command decoding. Releasing the remote-enable level drops remote mode and lockout at the next edge.

All outputs are registered. Every effect of a strobed byte shows at the rising clock edge that samples the strobe.

Top module: `atn_cmd_decoder`

## Requirements
- R1: A strobed byte with attention released appears on `dataByte` with `dataStrobe` high for exactly the next cycle, unchanged in all 8 bits, and changes no role or pulse output.
- R2: With attention asserted, the byte's bit 7 is ignored. Values 0x20–0x3E of bits 6:0 are listen addresses and 0x40–0x5E are talk addresses, with the address in bits 4:0.
- R3: The own talk address sets `talkActive` and clears `listenActive`. The own listen address sets `listenActive` and clears `talkActive`. The two are never high together.
- R4: 0x3F clears `listenActive` and 0x5F clears `talkActive`. A talk address other than the own one clears `talkActive`. With `ownAddr` = 31 the device is never addressed.
- R5: 0x14 pulses `clearPulse` for one cycle whatever the addressing. 0x04 pulses it only when `listenActive` was high before the byte.
- R6: 0x08 pulses `triggerPulse` for one cycle only when `listenActive` was high before the byte.
- R7: 0x11 sets `lockoutOn` while `renLevel` is high. The byte has no effect while `renLevel` is low.
- R8: 0x01 clears `remoteMode` only when `listenActive` was high before the byte.
- R9: The own listen address received with `renLevel` high sets `remoteMode`. While `renLevel` is low, `remoteMode` and `lockoutOn` are forced low from the next edge.
- R10: While `ifcLevel` is high, `talkActive` and `listenActive` clear at the next edge and strobed command bytes have no effect.
- R11: After reset all outputs are low. Every output updates at the edge that samples the strobe, and pulses last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxStrobe | input | 1 | One-cycle strobe for an accepted byte |
| rxByte | input | 8 | Accepted byte |
| atnLevel | input | 1 | Attention asserted (command mode) |
| ifcLevel | input | 1 | Interface clear asserted |
| renLevel | input | 1 | Remote enable asserted |
| ownAddr | input | 5 | Configured device address |
| talkActive | output | 1 | Device is addressed to talk |
| listenActive | output | 1 | Device is addressed to listen |
| remoteMode | output | 1 | Device is under remote control |
| lockoutOn | output | 1 | Local controls locked out |
| clearPulse | output | 1 | One-cycle device clear request |
| triggerPulse | output | 1 | One-cycle trigger request |
| dataStrobe | output | 1 | One-cycle strobe for forwarded device data |
| dataByte | output | 8 | Last forwarded device data byte |

## Verification
The listener flag is the block's hidden gate. A wrong value of it stays invisible until a selected clear, trigger or go-to-local byte arrives. At that point it shows as a missing or extra pulse, or as a remote flag that fails to drop, in the very next cycle. That is why the bench compares every output on every cycle against a behavioural model and drives long random mixes of addressed commands. A wrong role or remote state left by an interface-clear or remote-enable edge appears on the flag outputs one cycle after the level is sampled.

// File: rtl/atn_cmd_pkg.sv
package atn_cmd_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int CODE_W = DATA_W - 1;

  localparam logic [CODE_W-1:0] CODE_GTL = 7'h01;
  localparam logic [CODE_W-1:0] CODE_SDC = 7'h04;
  localparam logic [CODE_W-1:0] CODE_GET = 7'h08;
  localparam logic [CODE_W-1:0] CODE_LLO = 7'h11;
  localparam logic [CODE_W-1:0] CODE_DCL = 7'h14;

  localparam logic [1:0] GROUP_LISTEN = 2'b01;
  localparam logic [1:0] GROUP_TALK   = 2'b10;

  typedef struct packed {
    logic myListen;
    logic myTalk;
    logic unListen;
    logic unTalk;
    logic otherTalk;
    logic devClear;
    logic selClear;
    logic trigger;
    logic goLocal;
    logic lockout;
  } cmdStrobes_t;
endpackage

// File: rtl/atn_cmd_control.sv
module atn_cmd_control
  import atn_cmd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          rxStrobe,
  input  logic [DW-1:0] rxByte,
  input  logic          atnLevel,
  input  logic          ifcLevel,
  input  logic [AW-1:0] ownAddr,
  output cmdStrobes_t   cmdOut
);
  localparam int CW = DW - 1;
  localparam logic [AW-1:0] NOBODY = '1;

  logic          cmdValid;
  logic [CW-1:0] cmdCode;
  logic [1:0]    cmdGroup;
  logic [AW-1:0] cmdAddr;
  logic          isListenGrp;
  logic          isTalkGrp;
  logic          addrIsNobody;
  logic          addrIsMine;

  assign cmdValid     = rxStrobe && atnLevel && !ifcLevel;
  assign cmdCode      = rxByte[CW-1:0];
  assign cmdGroup     = cmdCode[CW-1:CW-2];
  assign cmdAddr      = cmdCode[AW-1:0];
  assign isListenGrp  = cmdValid && (cmdGroup == GROUP_LISTEN);
  assign isTalkGrp    = cmdValid && (cmdGroup == GROUP_TALK);
  assign addrIsNobody = (cmdAddr == NOBODY);
  assign addrIsMine   = (cmdAddr == ownAddr) && !addrIsNobody;

  always_comb begin
    cmdOut           = '0;
    cmdOut.unListen  = isListenGrp && addrIsNobody;
    cmdOut.myListen  = isListenGrp && addrIsMine;
    cmdOut.unTalk    = isTalkGrp && addrIsNobody;
    cmdOut.myTalk    = isTalkGrp && addrIsMine;
    cmdOut.otherTalk = isTalkGrp && !addrIsNobody && !addrIsMine;
    if (cmdValid) begin
      cmdOut.devClear = (cmdCode == CODE_DCL);
      cmdOut.selClear = (cmdCode == CODE_SDC);
      cmdOut.trigger  = (cmdCode == CODE_GET);
      cmdOut.goLocal  = (cmdCode == CODE_GTL);
      cmdOut.lockout  = (cmdCode == CODE_LLO);
    end
  end
endmodule

// File: rtl/atn_cmd_datapath.sv
module atn_cmd_datapath
  import atn_cmd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmdStrobes_t   cmdIn,
  input  logic          rxStrobe,
  input  logic [DW-1:0] rxByte,
  input  logic          atnLevel,
  input  logic          ifcLevel,
  input  logic          renLevel,
  output logic          talkActive,
  output logic          listenActive,
  output logic          remoteMode,
  output logic          lockoutOn,
  output logic          clearPulse,
  output logic          triggerPulse,
  output logic          dataStrobe,
  output logic [DW-1:0] dataByte
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      talkActive   <= 1'b0;
      listenActive <= 1'b0;
    end else if (ifcLevel) begin
      talkActive   <= 1'b0;
      listenActive <= 1'b0;
    end else begin
      if (cmdIn.myTalk) talkActive <= 1'b1;
      else if (cmdIn.myListen || cmdIn.unTalk || cmdIn.otherTalk) talkActive <= 1'b0;
      if (cmdIn.myListen) listenActive <= 1'b1;
      else if (cmdIn.myTalk || cmdIn.unListen) listenActive <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !renLevel) begin
      remoteMode <= 1'b0;
      lockoutOn  <= 1'b0;
    end else begin
      if (cmdIn.myListen) remoteMode <= 1'b1;
      else if (cmdIn.goLocal && listenActive) remoteMode <= 1'b0;
      if (cmdIn.lockout) lockoutOn <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clearPulse   <= 1'b0;
      triggerPulse <= 1'b0;
    end else begin
      clearPulse   <= cmdIn.devClear || (cmdIn.selClear && listenActive);
      triggerPulse <= cmdIn.trigger && listenActive;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataStrobe <= 1'b0;
      dataByte   <= '0;
    end else begin
      dataStrobe <= rxStrobe && !atnLevel;
      if (rxStrobe && !atnLevel) dataByte <= rxByte;
    end
  end

  assert_role_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(talkActive && listenActive));
  assert_trigger_needs_listener_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(triggerPulse) |-> $past(listenActive));
  assert_ifc_drops_roles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ifcLevel |=> (!talkActive && !listenActive));
  assert_ren_release_local_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !renLevel |=> (!remoteMode && !lockoutOn));
  assert_remote_needs_ren_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(remoteMode) |-> $past(renLevel));
  assert_data_from_released_atn_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rxStrobe && !atnLevel) |=> (dataStrobe && dataByte == $past(rxByte)));
endmodule

// File: rtl/atn_cmd_decoder.sv
module atn_cmd_decoder
  import atn_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxStrobe,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              atnLevel,
  input  logic              ifcLevel,
  input  logic              renLevel,
  input  logic [ADDR_W-1:0] ownAddr,
  output logic              talkActive,
  output logic              listenActive,
  output logic              remoteMode,
  output logic              lockoutOn,
  output logic              clearPulse,
  output logic              triggerPulse,
  output logic              dataStrobe,
  output logic [DATA_W-1:0] dataByte
);
  cmdStrobes_t cmdLink;

  atn_cmd_control #(.AW(ADDR_W), .DW(DATA_W)) i_control (
    .rxStrobe (rxStrobe),
    .rxByte   (rxByte),
    .atnLevel (atnLevel),
    .ifcLevel (ifcLevel),
    .ownAddr  (ownAddr),
    .cmdOut   (cmdLink)
  );

  atn_cmd_datapath #(.DW(DATA_W)) i_datapath (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmdIn        (cmdLink),
    .rxStrobe     (rxStrobe),
    .rxByte       (rxByte),
    .atnLevel     (atnLevel),
    .ifcLevel     (ifcLevel),
    .renLevel     (renLevel),
    .talkActive   (talkActive),
    .listenActive (listenActive),
    .remoteMode   (remoteMode),
    .lockoutOn    (lockoutOn),
    .clearPulse   (clearPulse),
    .triggerPulse (triggerPulse),
    .dataStrobe   (dataStrobe),
    .dataByte     (dataByte)
  );
endmodule

// File: tb/test_atn_cmd_decoder.sv
module test_atn_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxStrobe = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic atnLevel = 1'b0;
  logic ifcLevel = 1'b0;
  logic renLevel = 1'b0;
  logic [4:0] ownAddr = 5'd5;
  logic talkActive, listenActive, remoteMode, lockoutOn;
  logic clearPulse, triggerPulse, dataStrobe;
  logic [7:0] dataByte;

  int compared = 0;
  int mismatched = 0;
  int cycleCount = 0;

  // behavioural model state
  bit mT, mL, mR, mK, mC, mG, mD;
  int mB;

  always #(CLK_PERIOD/2) clk = ~clk;

  atn_cmd_decoder i_atn_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .rxStrobe(rxStrobe), .rxByte(rxByte),
    .atnLevel(atnLevel), .ifcLevel(ifcLevel), .renLevel(renLevel), .ownAddr(ownAddr),
    .talkActive(talkActive), .listenActive(listenActive), .remoteMode(remoteMode),
    .lockoutOn(lockoutOn), .clearPulse(clearPulse), .triggerPulse(triggerPulse),
    .dataStrobe(dataStrobe), .dataByte(dataByte)
  );

  task automatic check(input string req, input string what, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, actual, expected, cycleCount);
    end
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (!rst_n) begin
      mT = 0; mL = 0; mR = 0; mK = 0; mC = 0; mG = 0; mD = 0; mB = 0;
    end else begin
      bit oldL;
      int c;
      int a;
      oldL = mL;
      mC = 0; mG = 0; mD = 0;
      c = int'(rxByte) % 128;
      a = c % 32;
      if (rxStrobe && !atnLevel) begin
        mD = 1;
        mB = int'(rxByte);
      end
      if (rxStrobe && atnLevel && !ifcLevel) begin
        if (c == 'h3F) mL = 0;
        else if (c >= 'h20 && c < 'h3F && a == int'(ownAddr)) begin
          mL = 1; mT = 0;
          if (renLevel) mR = 1;
        end
        if (c == 'h5F) mT = 0;
        else if (c >= 'h40 && c < 'h5F) begin
          if (a == int'(ownAddr)) begin mT = 1; mL = 0; end
          else mT = 0;
        end
        if (c == 'h14) mC = 1;
        if (c == 'h04 && oldL) mC = 1;
        if (c == 'h08 && oldL) mG = 1;
        if (c == 'h01 && oldL) mR = 0;
        if (c == 'h11) mK = 1;
      end
      if (ifcLevel) begin mT = 0; mL = 0; end
      if (!renLevel) begin mR = 0; mK = 0; end
    end
  end

  always @(negedge clk) begin
    if (cycleCount > 0) begin
      check("R3", "talkActive", int'(talkActive), int'(mT));
      check("R3", "listenActive", int'(listenActive), int'(mL));
      check("R9", "remoteMode", int'(remoteMode), int'(mR));
      check("R7", "lockoutOn", int'(lockoutOn), int'(mK));
      check("R5", "clearPulse", int'(clearPulse), int'(mC));
      check("R6", "triggerPulse", int'(triggerPulse), int'(mG));
      check("R1", "dataStrobe", int'(dataStrobe), int'(mD));
      check("R1", "dataByte", int'(dataByte), mB);
    end
  end

  always @(negedge clk) begin
    if (cycleCount > WATCHDOG_CYCLES) begin
      mismatched++;
      $display("FAIL R11 watchdog: actual %0d cycles expected below %0d", cycleCount, WATCHDOG_CYCLES);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // drive one byte at a falling edge; on return the result of that byte is visible
  task automatic sendByte(input bit atn, input logic [7:0] b);
    @(negedge clk);
    atnLevel = atn;
    rxByte = b;
    rxStrobe = 1'b1;
    @(negedge clk);
    rxStrobe = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: reset state
    check("R11", "reset talk", int'(talkActive), 0);
    check("R11", "reset listen", int'(listenActive), 0);
    check("R11", "reset remote", int'(remoteMode), 0);
    check("R11", "reset pulses", int'({clearPulse, triggerPulse, dataStrobe}), 0);

    renLevel = 1'b1;
    sendByte(1, 8'h25);                       // own listen, own = 5
    check("R9", "remote on own listen", int'(remoteMode), 1);
    check("R3", "listener set", int'(listenActive), 1);
    sendByte(1, 8'h08);
    check("R6", "trigger when listener", int'(triggerPulse), 1);
    @(negedge clk); #1;
    check("R11", "trigger one cycle", int'(triggerPulse), 0);
    sendByte(1, 8'hC5);                       // own talk with bit 7 set
    check("R2", "bit7 ignored talk", int'(talkActive), 1);
    check("R3", "talk clears listen", int'(listenActive), 0);
    sendByte(1, 8'h08);
    check("R6", "no trigger unaddressed", int'(triggerPulse), 0);
    sendByte(1, 8'h04);
    check("R5", "no selected clear", int'(clearPulse), 0);
    sendByte(1, 8'h14);
    check("R5", "universal clear", int'(clearPulse), 1);
    sendByte(0, 8'h25);
    check("R1", "data strobe", int'(dataStrobe), 1);
    check("R1", "data byte", int'(dataByte), 'h25);
    check("R1", "data not decoded", int'(listenActive), 0);
    sendByte(1, 8'h46);
    check("R4", "other talk clears talk", int'(talkActive), 0);
    sendByte(1, 8'h25);
    sendByte(1, 8'h04);
    check("R5", "selected clear when listener", int'(clearPulse), 1);
    sendByte(1, 8'h11);
    check("R7", "lockout set", int'(lockoutOn), 1);
    sendByte(1, 8'h01);
    check("R8", "go local", int'(remoteMode), 0);
    sendByte(1, 8'h3F);
    check("R4", "unlisten", int'(listenActive), 0);
    @(negedge clk);
    renLevel = 1'b0;
    @(negedge clk); #1;
    check("R9", "ren release clears lockout", int'(lockoutOn), 0);
    sendByte(1, 8'h11);
    check("R7", "lockout ignored without ren", int'(lockoutOn), 0);
    ifcLevel = 1'b1;
    sendByte(1, 8'h25);
    check("R10", "command ignored in ifc", int'(listenActive), 0);
    ifcLevel = 1'b0;
    sendByte(1, 8'h45);
    ifcLevel = 1'b1;
    @(negedge clk); #1;
    check("R10", "ifc clears talker", int'(talkActive), 0);
    ifcLevel = 1'b0;
    ownAddr = 5'd31;
    sendByte(1, 8'h3F);
    check("R4", "address 31 never listens", int'(listenActive), 0);
    sendByte(1, 8'h5F);
    check("R4", "address 31 never talks", int'(talkActive), 0);

    // random phase, compared against the model on every cycle
    for (int phase = 0; phase < 3; phase++) begin
      ownAddr = (phase == 0) ? 5'd0 : (phase == 1) ? 5'd30 : 5'd9;
      for (int i = 0; i < 4000; i++) begin
        int pick;
        @(negedge clk);
        rxStrobe = ($urandom % 2) == 0;
        atnLevel = ($urandom % 10) < 7;
        pick = $urandom % 12;
        case (pick)
          0: rxByte = {1'($urandom % 2), 2'b01, ownAddr};
          1: rxByte = {1'($urandom % 2), 2'b10, ownAddr};
          2: rxByte = 8'h3F;
          3: rxByte = 8'h5F;
          4: rxByte = 8'h08;
          5: rxByte = 8'h04;
          6: rxByte = 8'h14;
          7: rxByte = 8'h01;
          8: rxByte = 8'h11;
          default: rxByte = 8'($urandom);
        endcase
        if (($urandom % 40) == 0) ifcLevel = ~ifcLevel;
        else if (ifcLevel && ($urandom % 3) == 0) ifcLevel = 1'b0;
        if (($urandom % 25) == 0) renLevel = ~renLevel;
      end
    end
    @(negedge clk);
    rxStrobe = 1'b0;
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule